// File: doc/BRIEF.md
# Three-Stage Watchdog Timer Bank

A bank of independent watchdog timers reached through a 64-bit register interface. Software can pick any timer as its system watchdog. Each timer holds a 24-bit live count that drops by one on a shared coarse tick, which comes once every 1024 clocks. When the count is zero at a tick, the timer expires: it reloads from its 16-bit length, with the low 8 count bits forced to zero, and moves its escalation stage forward.

Depending on the timer's mode, expiries lead to three actions in turn:
- the first sets the timer's bit in a shared interrupt-pending register, which drives the CPU interrupt through a per-timer enable mask;
- the second gives an optional one-cycle pulse toward a secondary controller;
- the third gives a one-cycle reset request.

Writing 1 to a timer's poke register reloads its count and sends it back to the first stage.

Register reads are combinational: `rdata_o` reflects the address on the same cycle that `req_i` is high with `we_i` low. Writes take effect at the clock edge that samples them. Only 8-byte-aligned addresses decode.

Top module: `wdt_bank`

## Requirements
- R1: After reset every configuration word reads 0, the pending and enable registers read 0, `irq_o` is low and no secondary or reset pulse is driven.
- R2: The configuration word of timer i is at byte offset 8*i. Its fields are:
  - bits [1:0]: mode;
  - bit 2: secondary-interrupt enable;
  - bits [19:4]: length;
  - bits [43:20]: live count, read-only.

  All other bits read 0. Writing the word loads the count with {length, 8'h00} and returns the timer to the first stage.
- R3: While the mode is not 0, the count drops by exactly 1 every 1024 clocks. In mode 0 the count holds and no expiry occurs.
- R4: A timer expires on a tick that finds its count at 0. It then reloads {length, 8'h00}, so successive expiries are (length*256+1)*1024 clocks apart.
- R5: Mode 1 sets the pending bit on every expiry and never drives a secondary or reset pulse.
- R6: Mode 2 sets the pending bit on a first-stage expiry. The next expiry drives the secondary pulse and returns the timer to the first stage.
- R7: Mode 3 behaves as mode 2 for its first two expiries. The third expiry drives a one-cycle reset pulse on `rst_req_o[i]`, after which the timer is in the first stage with its mode unchanged.
- R8: With the secondary enable at 0 the second expiry drives no pulse, but it still advances the stage, so the reset follows on the third expiry.
- R9: A write at 0x10000 + 8*i with data bit 0 set reloads timer i and returns it to the first stage. With bit 0 clear the write has no effect.
- R10: The pending register at 0x200 holds bit i for timer i. Writing 1 to a bit clears it, writing 0 leaves it, and a set in the same cycle wins over a clear.
- R11: Writing 1s at 0x218 sets enable bits and writing 1s at 0x210 clears them. Reading either address returns the mask. `irq_o` is high exactly when some pending bit has its enable set.
- R12: Configuration or poke accesses with an index of `NUM_TIMERS` or above read as 0 and are ignored on write. Bits for indices of `NUM_TIMERS` or above in the pending and enable registers read 0.
- R13: Timers are independent: events of one timer never cause pulses on another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 17 | Byte address |
| wdata_i | input | 64 | Write data |
| rdata_o | output | 64 | Read data, combinational |
| irq_o | output | 1 | CPU interrupt, OR of enabled pending bits |
| sec_irq_o | output | NUM_TIMERS | One-cycle secondary interrupt pulse per timer |
| rst_req_o | output | NUM_TIMERS | One-cycle reset request pulse per timer |

## Verification
Reads are due in the same cycle as the request. A write's effect is due from the cycle after the edge that samples it. The pending bit, and with it `irq_o`, rises the cycle after the expiry edge. The secondary pulse comes exactly one expiry period after that pending rise, and the reset pulse two periods after it, each lasting one cycle.

The tick phase is not aligned with configuration writes, so the bench does not predict absolute cycles. It samples at the falling edge, stamps each event with a cycle counter and checks the gaps between events against the period. Count decrements are checked by two reads exactly 1024 cycles apart, which always span exactly one tick.

// File: rtl/wdt_bank_pkg.sv
package wdt_bank_pkg;

  localparam int unsigned DATA_W    = 64;
  localparam int unsigned ADDR_W    = 17;
  localparam int unsigned IDX_W     = 6;
  localparam int unsigned LEN_W     = 16;
  localparam int unsigned CNT_LSB_W = 8;
  localparam int unsigned CNT_W     = LEN_W + CNT_LSB_W;

  localparam logic [ADDR_W-1:0] PEND_OFS  = 17'h00200;
  localparam logic [ADDR_W-1:0] ENCLR_OFS = 17'h00210;
  localparam logic [ADDR_W-1:0] ENSET_OFS = 17'h00218;

  typedef enum logic [1:0] {
    MODE_OFF = 2'd0,
    MODE_IRQ = 2'd1,
    MODE_SEC = 2'd2,
    MODE_RST = 2'd3
  } wdt_mode_e;

  typedef struct packed {
    wdt_mode_e        mode;
    logic             sec_en;
    logic [LEN_W-1:0] len;
  } wdt_cfg_t;

  function automatic wdt_cfg_t unpack_cfg(logic [DATA_W-1:0] w);
    wdt_cfg_t c;
    c.mode   = wdt_mode_e'(w[1:0]);
    c.sec_en = w[2];
    c.len    = w[19:4];
    return c;
  endfunction

  function automatic logic [DATA_W-1:0] pack_word(wdt_cfg_t c, logic [CNT_W-1:0] cnt);
    logic [DATA_W-1:0] w;
    w        = '0;
    w[1:0]   = c.mode;
    w[2]     = c.sec_en;
    w[19:4]  = c.len;
    w[43:20] = cnt;
    return w;
  endfunction

endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int unsigned TICK_DIV = 1024
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int unsigned PW = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(TICK_DIV - 1);

  logic [PW-1:0] pre_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            pre_q <= '0;
    else if (pre_q == LAST) pre_q <= '0;
    else                    pre_q <= pre_q + 1'b1;
  end

  assign tick_o = (pre_q == LAST);

  assert_tick_spacing_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);

endmodule

// File: rtl/wdt_timer.sv
module wdt_timer
  import wdt_bank_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             cfg_we_i,
  input  wdt_cfg_t         cfg_i,
  input  logic             poke_i,
  output wdt_cfg_t         cfg_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             cpu_exp_o,
  output logic             sec_irq_o,
  output logic             rst_req_o
);
  wdt_cfg_t         cfg_q;
  logic [CNT_W-1:0] cnt_q, cnt_d, reload;
  logic [1:0]       stage_q, stage_d;
  logic             sec_q, rst_q;
  logic             running, expire, sec_hit, rst_hit;

  always_comb begin
    reload    = {cfg_q.len, {CNT_LSB_W{1'b0}}};
    running   = (cfg_q.mode != MODE_OFF);
    // a register write in the same cycle overrides the expiry
    expire    = tick_i && running && (cnt_q == '0) && !cfg_we_i && !poke_i;
    cpu_exp_o = expire && (cfg_q.mode == MODE_IRQ || stage_q == 2'd0);
    sec_hit   = expire && (stage_q == 2'd1) &&
                (cfg_q.mode == MODE_SEC || cfg_q.mode == MODE_RST);
    rst_hit   = expire && (stage_q == 2'd2) && (cfg_q.mode == MODE_RST);

    stage_d = stage_q;
    if (cfg_we_i || poke_i) begin
      stage_d = 2'd0;
    end else if (expire) begin
      unique case (cfg_q.mode)
        MODE_SEC: stage_d = (stage_q == 2'd0) ? 2'd1 : 2'd0;
        MODE_RST: stage_d = (stage_q == 2'd2) ? 2'd0 : stage_q + 2'd1;
        default:  stage_d = 2'd0;
      endcase
    end

    if (cfg_we_i)                cnt_d = {cfg_i.len, {CNT_LSB_W{1'b0}}};
    else if (poke_i || expire)   cnt_d = reload;
    else if (tick_i && running)  cnt_d = cnt_q - 1'b1;
    else                         cnt_d = cnt_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q   <= '{mode: MODE_OFF, sec_en: 1'b0, len: '0};
      cnt_q   <= '0;
      stage_q <= 2'd0;
      sec_q   <= 1'b0;
      rst_q   <= 1'b0;
    end else begin
      if (cfg_we_i) cfg_q <= cfg_i;
      cnt_q   <= cnt_d;
      stage_q <= stage_d;
      sec_q   <= sec_hit && cfg_q.sec_en;
      rst_q   <= rst_hit;
    end
  end

  assign cfg_o     = cfg_q;
  assign cnt_o     = cnt_q;
  assign sec_irq_o = sec_q;
  assign rst_req_o = rst_q;

  assert_rst_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_q |=> !rst_q);
  assert_rst_mode_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_q |-> (cfg_q.mode == MODE_RST));
  assert_sec_gate_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_q |-> cfg_q.sec_en);
  assert_cnt_bound_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= {cfg_q.len, {CNT_LSB_W{1'b0}}});
  assert_off_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_q.mode == MODE_OFF && !cfg_we_i && !poke_i) |=> $stable(cnt_q));
  assert_irq_mode_stage_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_q.mode == MODE_IRQ) |-> (stage_q == 2'd0));

endmodule

// File: rtl/wdt_irq_regs.sv
module wdt_irq_regs #(
  parameter int unsigned NUM_TIMERS = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NUM_TIMERS-1:0] set_i,
  input  logic [NUM_TIMERS-1:0] pend_clr_i,
  input  logic [NUM_TIMERS-1:0] en_set_i,
  input  logic [NUM_TIMERS-1:0] en_clr_i,
  output logic [NUM_TIMERS-1:0] pend_o,
  output logic [NUM_TIMERS-1:0] en_o,
  output logic                  irq_o
);
  logic [NUM_TIMERS-1:0] pend_q, en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      en_q   <= '0;
    end else begin
      pend_q <= (pend_q & ~pend_clr_i) | set_i;
      en_q   <= (en_q & ~en_clr_i) | en_set_i;
    end
  end

  assign pend_o = pend_q;
  assign en_o   = en_q;
  assign irq_o  = |(pend_q & en_q);

  assert_w1c_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(pend_clr_i & ~set_i)) |=> ((pend_q & $past(pend_clr_i & ~set_i)) == '0));
  assert_pend_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_clr_i == '0) |=> ((pend_q & $past(pend_q)) == $past(pend_q)));
  assert_en_set_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_set_i != '0) |=> ((en_q & $past(en_set_i)) == $past(en_set_i)));

endmodule

// File: rtl/wdt_bank.sv
module wdt_bank
  import wdt_bank_pkg::*;
#(
  parameter int unsigned NUM_TIMERS = 4,
  parameter int unsigned TICK_DIV   = 1024
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  req_i,
  input  logic                  we_i,
  input  logic [16:0]           addr_i,
  input  logic [63:0]           wdata_i,
  output logic [63:0]           rdata_o,
  output logic                  irq_o,
  output logic [NUM_TIMERS-1:0] sec_irq_o,
  output logic [NUM_TIMERS-1:0] rst_req_o
);
  logic             tick;
  logic [IDX_W-1:0] idx;
  logic             aligned, in_cfg, in_poke, is_pend, is_enclr, is_enset, wr;
  wdt_cfg_t         new_cfg;

  wdt_cfg_t              cfg_q   [NUM_TIMERS];
  logic [CNT_W-1:0]      cnt_q   [NUM_TIMERS];
  logic [NUM_TIMERS-1:0] cpu_exp, pend, en;
  logic [NUM_TIMERS-1:0] pend_clr, en_set, en_clr;

  logic unused_wdata;
  assign unused_wdata = ^{wdata_i[63:20], wdata_i[3]};

  always_comb begin
    idx      = addr_i[8:3];
    aligned  = (addr_i[2:0] == 3'd0);
    in_cfg   = aligned && (addr_i[16:9] == '0);
    in_poke  = aligned && addr_i[16] && (addr_i[15:9] == '0);
    is_pend  = (addr_i == PEND_OFS);
    is_enclr = (addr_i == ENCLR_OFS);
    is_enset = (addr_i == ENSET_OFS);
    wr       = req_i && we_i;
    new_cfg  = unpack_cfg(wdata_i);
    pend_clr = (wr && is_pend)  ? wdata_i[NUM_TIMERS-1:0] : '0;
    en_clr   = (wr && is_enclr) ? wdata_i[NUM_TIMERS-1:0] : '0;
    en_set   = (wr && is_enset) ? wdata_i[NUM_TIMERS-1:0] : '0;
  end

  wdt_prescaler #(.TICK_DIV(TICK_DIV)) u_pre (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_o(tick)
  );

  for (genvar i = 0; i < NUM_TIMERS; i++) begin : g_tmr
    logic cfg_we, poke;
    assign cfg_we = wr && in_cfg  && (idx == IDX_W'(i));
    assign poke   = wr && in_poke && (idx == IDX_W'(i)) && wdata_i[0];

    wdt_timer u_tmr (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .tick_i   (tick),
      .cfg_we_i (cfg_we),
      .cfg_i    (new_cfg),
      .poke_i   (poke),
      .cfg_o    (cfg_q[i]),
      .cnt_o    (cnt_q[i]),
      .cpu_exp_o(cpu_exp[i]),
      .sec_irq_o(sec_irq_o[i]),
      .rst_req_o(rst_req_o[i])
    );
  end

  wdt_irq_regs #(.NUM_TIMERS(NUM_TIMERS)) u_irq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_i     (cpu_exp),
    .pend_clr_i(pend_clr),
    .en_set_i  (en_set),
    .en_clr_i  (en_clr),
    .pend_o    (pend),
    .en_o      (en),
    .irq_o     (irq_o)
  );

  always_comb begin
    rdata_o = '0;
    if (req_i && !we_i) begin
      if (in_cfg) begin
        for (int i = 0; i < NUM_TIMERS; i++)
          if (idx == IDX_W'(i)) rdata_o = pack_word(cfg_q[i], cnt_q[i]);
      end else if (is_pend) begin
        rdata_o[NUM_TIMERS-1:0] = pend;
      end else if (is_enclr || is_enset) begin
        rdata_o[NUM_TIMERS-1:0] = en;
      end
    end
  end

  assert_pulse_independent_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(rst_req_o) <= 1 || $past(tick));

endmodule

// File: tb/test_wdt_bank.sv
module test_wdt_bank;
  localparam int N = 4;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          req_i = 1'b0, we_i = 1'b0;
  logic [16:0]   addr_i = '0;
  logic [63:0]   wdata_i = '0;
  logic [63:0]   rdata_o;
  logic          irq_o;
  logic [N-1:0]  sec_irq_o, rst_req_o;

  int n_chk = 0, n_fail = 0, cyc = 0;
  int sec_cnt [N];
  int rst_cnt [N];
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  wdt_bank #(.NUM_TIMERS(N), .TICK_DIV(1024)) i_wdt_bank (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i, .rdata_o,
    .irq_o, .sec_irq_o, .rst_req_o
  );

  always @(posedge clk_i) cyc <= cyc + 1;

  always @(negedge clk_i) if (rst_ni)
    for (int t = 0; t < N; t++) begin
      sec_cnt[t] += int'(sec_irq_o[t]);
      rst_cnt[t] += int'(rst_req_o[t]);
    end

  function automatic logic [63:0] word(int mode, bit sec, logic [15:0] len, logic [23:0] cnt);
    return {20'h0, cnt, len, 1'b0, sec, 2'(mode)};
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [16:0] a, logic [63:0] d);
    @(negedge clk_i);
    req_i = 1; we_i = 1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    req_i = 0; we_i = 0;
  endtask

  task automatic rd_now(logic [16:0] a, output logic [63:0] d);
    req_i = 1; we_i = 0; addr_i = a;
    #1 d = rdata_o;
    req_i = 0;
  endtask

  task automatic rd(logic [16:0] a, output logic [63:0] d);
    @(negedge clk_i);
    rd_now(a, d);
  endtask

  // kind 0: irq_o, 1: sec pulse, 2: reset pulse
  task automatic wait_evt(int kind, int t, int limit, output int at);
    at = -1;
    for (int k = 0; k < limit; k++) begin
      @(negedge clk_i);
      if ((kind == 0 && irq_o) || (kind == 1 && sec_irq_o[t]) ||
          (kind == 2 && rst_req_o[t])) begin
        at = cyc;
        break;
      end
    end
  endtask

  task automatic cleanup(int t);
    wr(17'(8 * t), 64'h0);
    wr(17'h210, 64'hF);
    wr(17'h200, 64'hF);
  endtask

  task automatic t_reset;
    logic [63:0] d;
    for (int t = 0; t < N; t++) begin
      rd(17'(8 * t), d);
      chk("R1 cfg reset", d, 64'h0);
    end
    rd(17'h200, d); chk("R1 pending reset", d, 64'h0);
    rd(17'h218, d); chk("R1 enable reset", d, 64'h0);
    chk("R1 irq reset", 64'(irq_o), 64'h0);
    chk("R1 pulses reset", 64'({sec_irq_o, rst_req_o}), 64'h0);
  endtask

  task automatic t_layout;
    logic [63:0] d;
    wr(17'h08, 64'hFFFF_FFFF_FFFA_BCD4);
    rd_now(17'h08, d);
    chk("R2 layout and load", d, word(0, 1, 16'hABCD, 24'hABCD00));
    repeat (2100) @(negedge clk_i);
    rd_now(17'h08, d);
    chk("R3 mode 0 holds count", d, word(0, 1, 16'hABCD, 24'hABCD00));
    chk("R3 mode 0 no pulses", 64'(sec_cnt[1] + rst_cnt[1]), 64'h0);
    cleanup(1);
  endtask

  task automatic t_decrement;
    logic [63:0] a, b;
    wr(17'h10, word(1, 0, 16'h0001, 24'h0));
    rd_now(17'h10, a);
    chk("R2 reload on write", a[43:20], 64'h100);
    repeat (1024) @(negedge clk_i);
    rd_now(17'h10, b);
    chk("R3 one decrement per 1024", b[43:20], 64'hFF);
    repeat (1024) @(negedge clk_i);
    rd_now(17'h10, b);
    chk("R3 second decrement", b[43:20], 64'hFE);
    cleanup(2);
  endtask

  task automatic t_mode3;
    logic [63:0] d;
    int c0, c1, c2, c3;
    wr(17'h218, 64'h8);
    rd(17'h210, d); chk("R11 enable read at clear", d, 64'h8);
    rd(17'h218, d); chk("R11 enable read at set", d, 64'h8);
    wr(17'h18, word(3, 1, 16'h0, 24'h0));
    wait_evt(0, 3, 1100, c0);
    chk("R4 first expiry seen", 64'(c0 >= 0), 64'h1);
    wait_evt(1, 3, 1100, c1);
    chk("R6 secondary after one period", 64'(c1 - c0), 64'd1024);
    wait_evt(2, 3, 1100, c2);
    chk("R7 reset after two periods", 64'(c2 - c0), 64'd2048);
    @(negedge clk_i);
    chk("R7 reset one cycle", 64'(rst_req_o[3]), 64'h0);
    rd_now(17'h18, d); chk("R7 mode kept", 64'(d[1:0]), 64'h3);
    rd(17'h200, d); chk("R10 pending bit 3", d, 64'h8);
    chk("R11 irq with pending and enable", 64'(irq_o), 64'h1);
    wr(17'h200, 64'h8);
    rd_now(17'h200, d); chk("R10 write-1 clear", d, 64'h0);
    chk("R11 irq low after clear", 64'(irq_o), 64'h0);
    wait_evt(0, 3, 1100, c3);
    chk("R7 back to first stage", 64'(c3 - c0), 64'd3072);
    cleanup(3);
  endtask

  task automatic t_mode1_mask;
    logic [63:0] d;
    int c0, c1, s0, r0;
    s0 = sec_cnt[0]; r0 = rst_cnt[0];
    wr(17'h00, word(1, 1, 16'h0, 24'h0));
    repeat (1100) @(negedge clk_i);
    rd_now(17'h200, d); chk("R5 pending set in mode 1", d, 64'h1);
    chk("R11 masked irq low", 64'(irq_o), 64'h0);
    wr(17'h218, 64'hF1);
    chk("R11 irq after enable set", 64'(irq_o), 64'h1);
    rd_now(17'h218, d); chk("R12 enable bits above range read 0", d, 64'h1);
    wr(17'h210, 64'h1);
    chk("R11 irq after enable clear", 64'(irq_o), 64'h0);
    wr(17'h218, 64'h1);
    wr(17'h200, 64'h1);
    wait_evt(0, 0, 1100, c0);
    wr(17'h200, 64'h1);
    wait_evt(0, 0, 1100, c1);
    chk("R5 interrupt every expiry", 64'(c1 - c0), 64'd1024);
    wr(17'h200, 64'h1);
    wait_evt(0, 0, 1100, c1);
    chk("R5 third interrupt", 64'(c1 - c0), 64'd2048);
    chk("R5 no secondary or reset", 64'(sec_cnt[0] - s0 + rst_cnt[0] - r0), 64'h0);
    cleanup(0);
  endtask

  task automatic t_mode2;
    int c0, c1, c2, r0;
    r0 = rst_cnt[1];
    wr(17'h218, 64'h2);
    wr(17'h08, word(2, 1, 16'h0, 24'h0));
    wait_evt(0, 1, 1100, c0);
    wr(17'h200, 64'h2);
    wait_evt(1, 1, 1100, c1);
    chk("R6 secondary in mode 2", 64'(c1 - c0), 64'd1024);
    wait_evt(0, 1, 1100, c2);
    chk("R6 returns to first stage", 64'(c2 - c0), 64'd2048);
    chk("R6 no reset in mode 2", 64'(rst_cnt[1] - r0), 64'h0);
    cleanup(1);
  endtask

  task automatic t_sec_off;
    int c0, c2, s0;
    s0 = sec_cnt[2];
    wr(17'h218, 64'h4);
    wr(17'h10, word(3, 0, 16'h0, 24'h0));
    wait_evt(0, 2, 1100, c0);
    wait_evt(2, 2, 2200, c2);
    chk("R8 reset still on third expiry", 64'(c2 - c0), 64'd2048);
    chk("R8 no secondary pulse", 64'(sec_cnt[2] - s0), 64'h0);
    cleanup(2);
  endtask

  task automatic t_poke;
    int c0, c1, c2, c3, s0;
    wr(17'h218, 64'h8);
    wr(17'h18, word(3, 1, 16'h0, 24'h0));
    wait_evt(0, 3, 1100, c0);
    s0 = sec_cnt[3];
    wr(17'h200, 64'h8);
    wr(17'h10018, 64'h1);
    wait_evt(0, 3, 1100, c1);
    chk("R9 poke restarts first stage", 64'(c1 - c0), 64'd1024);
    chk("R9 no secondary after poke", 64'(sec_cnt[3] - s0), 64'h0);
    wr(17'h200, 64'h8);
    wr(17'h10018, 64'h0);
    wait_evt(1, 3, 1100, c2);
    chk("R9 poke with bit0 clear ignored", 64'(c2 - c1), 64'd1024);
    wait_evt(2, 3, 1100, c3);
    chk("R7 reset follows", 64'(c3 - c1), 64'd2048);
    cleanup(3);
  endtask

  task automatic t_range;
    logic [63:0] d;
    int c, r0;
    r0 = rst_cnt[0] + rst_cnt[1] + rst_cnt[2] + rst_cnt[3];
    wr(17'h28, word(3, 1, 16'h1234, 24'h0));
    rd_now(17'h28, d); chk("R12 out-of-range cfg reads 0", d, 64'h0);
    wr(17'h10028, 64'h1);
    rd_now(17'h10028, d); chk("R12 poke space reads 0", d, 64'h0);
    rd_now(17'h208, d); chk("R12 unmapped reads 0", d, 64'h0);
    for (int t = 0; t < N; t++) begin
      rd(17'(8 * t), d);
      chk("R12 in-range timers untouched", d, 64'h0);
    end
    wr(17'h218, 64'hF);
    wait_evt(0, 0, 2200, c);
    chk("R12 no timer armed", 64'(c), 64'hFFFF_FFFF_FFFF_FFFF);
    chk("R13 no reset on idle timers",
        64'(rst_cnt[0] + rst_cnt[1] + rst_cnt[2] + rst_cnt[3] - r0), 64'h0);
    chk("R13 timers 0 and 1 never reset", 64'(rst_cnt[0] + rst_cnt[1]), 64'h0);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    for (int t = 0; t < N; t++) begin sec_cnt[t] = 0; rst_cnt[t] = 0; end
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset;
    t_layout;
    t_decrement;
    t_mode3;
    t_mode1_mask;
    t_mode2;
    t_sec_off;
    t_poke;
    t_range;
    finish_run;
  end

  initial begin
    wait (cyc > 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
    finish_run;
  end

endmodule